// File: doc/BRIEF.md
# Byte-Granular Shift and Rotate Unit

This block moves the magnitude bits of an accumulator register (A) and an extension register (X) by whole bytes of six bits. It either shifts A alone, shifts A and X joined into one ten-byte value with A as the upper half, or rotates that ten-byte value circularly. The shift distance is a byte count that arrives in sign-magnitude form. The sign bit of each register never moves.

The unit works over several cycles. It accepts a request on a one-cycle `start` pulse while it is idle. It then moves one byte position per clock and raises `done` for one cycle when the result is on its outputs. Results stay on the outputs until the next accepted request. The caller produces the count and writes the results back to the registers; this block does neither.

Top module: `byte_shift_unit`

## Requirements
- R1: After reset, `busy`, `done`, `err`, both sign outputs and both magnitude outputs are all zero.
- R2: With `modeSel` = 3'b000 (left) or 3'b001 (right), only A moves. Each step moves it one byte, and zero bytes fill the vacated end. `xMagOut` equals `xMagIn`. A count of 5 or more clears A.
- R3: With `modeSel` = 3'b010 (left) or 3'b011 (right), the 60-bit value {A,X} shifts as one unit with zero fill. Bytes cross between the two halves. A count of 10 or more clears both halves.
- R4: When `modeSel[2]` is 1, {A,X} rotates by the count modulo 10 byte positions, with `modeSel[0]` choosing the direction (0 left, 1 right). The value of `modeSel[1]` has no effect in this case.
- R5: `aSignOut` and `xSignOut` equal the signs captured at the request, whatever the mode and count.
- R6: When `cntSign` is 1 and `cntMag` is nonzero, `err` is 1 alongside `done`, and both outputs equal the captured inputs. When `cntSign` is 1 and `cntMag` is 0, the request counts as a zero-byte move with `err` at 0.
- R7: If the start edge is E0, `done` is high for exactly one cycle, right after edge E0+k. Here k is the number of byte steps: the clamped count, the count modulo 10, or 0 for an error. `busy` is high between E0 and that point.
- R8: A `start` pulse while `busy` is high is dropped. It does not change the result in progress and causes no later `done`.
- R9: While idle with `start` low, all outputs hold their values, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only while idle |
| modeSel | input | 3 | bit2 circular, bit1 pair, bit0 right |
| aSignIn | input | 1 | Sign of A |
| aMagIn | input | 30 | Magnitude of A, five 6-bit bytes |
| xSignIn | input | 1 | Sign of X |
| xMagIn | input | 30 | Magnitude of X, five 6-bit bytes |
| cntSign | input | 1 | Sign of the byte count |
| cntMag | input | 12 | Magnitude of the byte count |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Negative count seen, held until next request |
| aSignOut | output | 1 | Resulting A sign |
| aMagOut | output | 30 | Resulting A magnitude |
| xSignOut | output | 1 | Resulting X sign |
| xMagOut | output | 30 | Resulting X magnitude |

## Verification
Each mode uses operands with a distinct value in every byte, so a result that is one position off, or uses the wrong direction, shows up as a different byte order. Single-register moves use a nonzero X to catch leakage into X. Pair moves use counts that push bytes across the A/X boundary, which separates a true pair shift from two independent register shifts. Rotations use counts of 10 and 13 to show the modulo reduction, and clamp counts of 5, 7 and 12 show that shifts clear rather than wrap. Negative zero against negative nonzero, and a second start while busy, isolate the error rule and the drop rule.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef struct packed {
    logic circ;
    logic pair;
    logic right;
  } shiftMode_t;

  typedef struct packed {
    logic load;
    logic step;
  } dpStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctlState_t;

endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
#(
  parameter int REG_BYTES = 5,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             circIn,
  input  logic             pairIn,
  input  logic             cntSign,
  input  logic [CNT_W-1:0] cntMag,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             done,
  output logic             err
);

  localparam int PAIR_BYTES = 2 * REG_BYTES;
  localparam int STEP_W     = $clog2(PAIR_BYTES + 1);

  ctlState_t         state;
  logic [STEP_W-1:0] remaining;
  logic [STEP_W-1:0] stepsNext;
  logic              cntNeg;
  logic              accept;

  assign cntNeg = cntSign && (cntMag != '0);
  assign accept = start && (state == ST_IDLE);

  // number of single-byte steps for the request being offered
  always_comb begin
    if (cntNeg) begin
      stepsNext = '0;
    end else if (circIn) begin
      stepsNext = STEP_W'(cntMag % CNT_W'(PAIR_BYTES));
    end else if (pairIn) begin
      stepsNext = (cntMag >= CNT_W'(PAIR_BYTES)) ? STEP_W'(PAIR_BYTES) : STEP_W'(cntMag);
    end else begin
      stepsNext = (cntMag >= CNT_W'(REG_BYTES)) ? STEP_W'(REG_BYTES) : STEP_W'(cntMag);
    end
  end

  assign strobe.load = accept;
  assign strobe.step = (state == ST_RUN);
  assign busy        = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        err <= cntNeg;
        if (stepsNext == '0) begin
          done <= 1'b1;
        end else begin
          state     <= ST_RUN;
          remaining <= stepsNext;
        end
      end else if (state == ST_RUN) begin
        remaining <= remaining - 1'b1;
        if (remaining == STEP_W'(1)) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bshift_dp.sv
module bshift_dp
  import bshift_pkg::*;
#(
  parameter int BYTE_W    = 6,
  parameter int REG_BYTES = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  shiftMode_t                    modeIn,
  input  logic                          aSignIn,
  input  logic [BYTE_W*REG_BYTES-1:0]   aMagIn,
  input  logic                          xSignIn,
  input  logic [BYTE_W*REG_BYTES-1:0]   xMagIn,
  output logic                          aSignOut,
  output logic [BYTE_W*REG_BYTES-1:0]   aMagOut,
  output logic                          xSignOut,
  output logic [BYTE_W*REG_BYTES-1:0]   xMagOut
);

  localparam int PAIR_BYTES = 2 * REG_BYTES;
  localparam int WORD_W     = BYTE_W * REG_BYTES;

  logic [PAIR_BYTES-1:0][BYTE_W-1:0] curB;
  logic [BYTE_W-1:0]                 stepB [PAIR_BYTES];
  shiftMode_t                        modeR;
  logic                              pairLike;

  assign pairLike = modeR.pair || modeR.circ;

  // one byte position of movement per step; index 0 is the lowest byte of X
  for (genvar gi = 0; gi < PAIR_BYTES; gi++) begin : g_byte
    logic [BYTE_W-1:0] fromBelow;
    logic [BYTE_W-1:0] fromAbove;

    if (gi == 0) begin : g_low
      assign fromBelow = modeR.circ ? curB[PAIR_BYTES-1] : '0;
    end else if (gi == REG_BYTES) begin : g_seam
      assign fromBelow = pairLike ? curB[gi-1] : '0;
    end else begin : g_mid
      assign fromBelow = curB[gi-1];
    end

    if (gi == PAIR_BYTES - 1) begin : g_top
      assign fromAbove = modeR.circ ? curB[0] : '0;
    end else begin : g_inner
      assign fromAbove = curB[gi+1];
    end

    if (gi < REG_BYTES) begin : g_xhalf
      assign stepB[gi] = !pairLike ? curB[gi] : (modeR.right ? fromAbove : fromBelow);
    end else begin : g_ahalf
      assign stepB[gi] = modeR.right ? fromAbove : fromBelow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curB     <= '0;
      modeR    <= '0;
      aSignOut <= 1'b0;
      xSignOut <= 1'b0;
    end else if (strobe.load) begin
      curB     <= {aMagIn, xMagIn};
      modeR    <= modeIn;
      aSignOut <= aSignIn;
      xSignOut <= xSignIn;
    end else if (strobe.step) begin
      for (int j = 0; j < PAIR_BYTES; j++) begin
        curB[j] <= stepB[j];
      end
    end
  end

  assign aMagOut = curB[PAIR_BYTES-1:REG_BYTES];
  assign xMagOut = WORD_W'(curB[REG_BYTES-1:0]);

endmodule

// File: rtl/byte_shift_unit.sv
module byte_shift_unit
  import bshift_pkg::*;
#(
  parameter int BYTE_W    = 6,
  parameter int REG_BYTES = 5,
  parameter int CNT_W     = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [2:0]                  modeSel,
  input  logic                        aSignIn,
  input  logic [BYTE_W*REG_BYTES-1:0] aMagIn,
  input  logic                        xSignIn,
  input  logic [BYTE_W*REG_BYTES-1:0] xMagIn,
  input  logic                        cntSign,
  input  logic [CNT_W-1:0]            cntMag,
  output logic                        busy,
  output logic                        done,
  output logic                        err,
  output logic                        aSignOut,
  output logic [BYTE_W*REG_BYTES-1:0] aMagOut,
  output logic                        xSignOut,
  output logic [BYTE_W*REG_BYTES-1:0] xMagOut
);

  shiftMode_t modeS;
  dpStrobe_t  strobe;

  assign modeS = shiftMode_t'(modeSel);

  bshift_ctrl #(
    .REG_BYTES (REG_BYTES),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .circIn  (modeS.circ),
    .pairIn  (modeS.pair),
    .cntSign (cntSign),
    .cntMag  (cntMag),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done),
    .err     (err)
  );

  bshift_dp #(
    .BYTE_W    (BYTE_W),
    .REG_BYTES (REG_BYTES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .modeIn   (modeS),
    .aSignIn  (aSignIn),
    .aMagIn   (aMagIn),
    .xSignIn  (xSignIn),
    .xMagIn   (xMagIn),
    .aSignOut (aSignOut),
    .aMagOut  (aMagOut),
    .xSignOut (xSignOut),
    .xMagOut  (xMagOut)
  );

endmodule

// File: rtl/bshift_checker.sv
module bshift_checker #(
  parameter int BYTE_W    = 6,
  parameter int REG_BYTES = 5
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        start,
  input logic [2:0]                  modeSel,
  input logic                        busy,
  input logic                        done,
  input logic                        err,
  input logic                        aSignOut,
  input logic [BYTE_W*REG_BYTES-1:0] aMagOut,
  input logic                        xSignOut,
  input logic [BYTE_W*REG_BYTES-1:0] xMagOut
);

  localparam int WORD_W = BYTE_W * REG_BYTES;

  logic ckCirc, ckPair, ckRight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckCirc  <= 1'b0;
      ckPair  <= 1'b0;
      ckRight <= 1'b0;
    end else if (start && !busy) begin
      ckCirc  <= modeSel[2];
      ckPair  <= modeSel[1];
      ckRight <= modeSel[0];
    end
  end

  AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(aSignOut) && $stable(xSignOut))); // R5

  AST_SINGLE_X_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ckCirc && !ckPair) |=> $stable(xMagOut)); // R2

  AST_SINGLE_LEFT_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ckCirc && !ckPair && !ckRight) |=> (aMagOut[BYTE_W-1:0] == '0)); // R2

  AST_SINGLE_RIGHT_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ckCirc && !ckPair && ckRight) |=> (aMagOut[WORD_W-1 -: BYTE_W] == '0)); // R2

  AST_PAIR_LEFT_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ckCirc && ckPair && !ckRight) |=> (xMagOut[BYTE_W-1:0] == '0)); // R3

  AST_ROT_KEEP_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ckCirc) |=>
      ($countones({aMagOut, xMagOut}) == $countones($past({aMagOut, xMagOut})))); // R4

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done); // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=>
      ($stable(aMagOut) && $stable(xMagOut) && $stable(aSignOut) && $stable(xSignOut))); // R9

endmodule

bind byte_shift_unit bshift_checker #(
  .BYTE_W    (BYTE_W),
  .REG_BYTES (REG_BYTES)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .modeSel  (modeSel),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .aSignOut (aSignOut),
  .aMagOut  (aMagOut),
  .xSignOut (xSignOut),
  .xMagOut  (xMagOut)
);

// File: tb/byte_shift_unit_tb_top.sv
`timescale 1ns/1ps
module byte_shift_unit_tb_top;

  localparam logic [2:0] M_SL  = 3'b000;
  localparam logic [2:0] M_SR  = 3'b001;
  localparam logic [2:0] M_PL  = 3'b010;
  localparam logic [2:0] M_PR  = 3'b011;
  localparam logic [2:0] M_RL  = 3'b100;
  localparam logic [2:0] M_RR  = 3'b101;
  localparam logic [2:0] M_RL2 = 3'b110;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  modeSel = '0;
  logic        aSignIn = 1'b0, xSignIn = 1'b0, cntSign = 1'b0;
  logic [29:0] aMagIn = '0, xMagIn = '0;
  logic [11:0] cntMag = '0;
  logic        busy, done, err, aSignOut, xSignOut;
  logic [29:0] aMagOut, xMagOut;

  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  byte_shift_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .aSignIn(aSignIn), .aMagIn(aMagIn), .xSignIn(xSignIn), .xMagIn(xMagIn),
    .cntSign(cntSign), .cntMag(cntMag),
    .busy(busy), .done(done), .err(err),
    .aSignOut(aSignOut), .aMagOut(aMagOut), .xSignOut(xSignOut), .xMagOut(xMagOut)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model built from the requirement text
  function automatic void model(input logic [2:0] m, input logic [29:0] a, input logic [29:0] x,
                                input logic cs, input logic [11:0] cm,
                                output logic [29:0] ea, output logic [29:0] ex,
                                output logic eerr, output int elat);
    logic [59:0] p, r;
    int k, sh;
    p = {a, x};
    ea = a; ex = x; eerr = 1'b0; elat = 0;
    if (cs && cm != 0) begin
      eerr = 1'b1;
    end else if (m[2]) begin
      k = int'(cm) % 10; sh = 6 * k;
      if (m[0]) r = (p >> sh) | (p << (60 - sh));
      else      r = (p << sh) | (p >> (60 - sh));
      ea = r[59:30]; ex = r[29:0]; elat = k;
    end else if (m[1]) begin
      k = (int'(cm) >= 10) ? 10 : int'(cm); sh = 6 * k;
      if (m[0]) r = p >> sh; else r = p << sh;
      ea = r[59:30]; ex = r[29:0]; elat = k;
    end else begin
      k = (int'(cm) >= 5) ? 5 : int'(cm); sh = 6 * k;
      if (m[0]) ea = a >> sh; else ea = a << sh;
      elat = k;
    end
  endfunction

  task automatic runOp(input string req, input logic [2:0] m,
                       input logic as, input logic [29:0] am,
                       input logic xs, input logic [29:0] xm,
                       input logic cs, input logic [11:0] cm);
    logic [29:0] ea, ex;
    logic eerr;
    int elat, lat;
    model(m, am, xm, cs, cm, ea, ex, eerr, elat);
    @(negedge clk);
    modeSel = m; aSignIn = as; aMagIn = am; xSignIn = xs; xMagIn = xm;
    cntSign = cs; cntMag = cm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R7", "done latency", 64'(lat), 64'(elat));
    check(req, "A magnitude", 64'(aMagOut), 64'(ea));
    check(req, "X magnitude", 64'(xMagOut), 64'(ex));
    check("R5", "signs", {62'd0, aSignOut, xSignOut}, {62'd0, as, xs});
    check("R6", "err flag", 64'(err), 64'(eerr));
    @(negedge clk);
    check("R7", "done one cycle", 64'(done), 64'd0);
  endtask

  task automatic tReset();
    check("R1", "reset outputs",
          {busy, done, err, aSignOut, xSignOut, aMagOut, xMagOut}, 64'd0);
  endtask

  task automatic tSingle();
    runOp("R2", M_SL, 1'b0, 30'h01083105, 1'b0, 30'h1A2B3C4D, 1'b0, 12'd2);
    runOp("R2", M_SR, 1'b0, 30'h3F1C8A65, 1'b0, 30'h12345678, 1'b0, 12'd3);
    runOp("R2", M_SL, 1'b0, 30'h3FFFFFFF, 1'b0, 30'h0000FFFF, 1'b0, 12'd5);
    runOp("R2", M_SR, 1'b0, 30'h2AAAAAAA, 1'b0, 30'h15555555, 1'b0, 12'd7);
    runOp("R2", M_SL, 1'b0, 30'h0ABCDEF1, 1'b0, 30'h00000001, 1'b0, 12'd0);
  endtask

  task automatic tPair();
    runOp("R3", M_PL, 1'b0, 30'h01083105, 1'b0, 30'h1C824A2B, 1'b0, 12'd3);
    runOp("R3", M_PR, 1'b0, 30'h01083105, 1'b0, 30'h1C824A2B, 1'b0, 12'd7);
    runOp("R3", M_PL, 1'b0, 30'h3FFFFFFF, 1'b0, 30'h3FFFFFFF, 1'b0, 12'd12);
    runOp("R3", M_PR, 1'b0, 30'h3FFFFFFF, 1'b0, 30'h00000000, 1'b0, 12'd5);
  endtask

  task automatic tRotate();
    runOp("R4", M_RL,  1'b0, 30'h01083105, 1'b0, 30'h1C824A2B, 1'b0, 12'd4);
    runOp("R4", M_RR,  1'b0, 30'h01083105, 1'b0, 30'h1C824A2B, 1'b0, 12'd13);
    runOp("R4", M_RL,  1'b0, 30'h2468ACE0, 1'b0, 30'h13579BDF, 1'b0, 12'd10);
    runOp("R4", M_RL2, 1'b0, 30'h01083105, 1'b0, 30'h1C824A2B, 1'b0, 12'd6);
  endtask

  task automatic tSigns();
    runOp("R5", M_PL, 1'b1, 30'h0F0F0F0F, 1'b0, 30'h30303030, 1'b0, 12'd2);
    runOp("R5", M_RR, 1'b0, 30'h0F0F0F0F, 1'b1, 30'h30303030, 1'b0, 12'd1);
    runOp("R5", M_SR, 1'b1, 30'h0F0F0F0F, 1'b1, 30'h30303030, 1'b0, 12'd1);
  endtask

  task automatic tNegative();
    runOp("R6", M_PL, 1'b1, 30'h01083105, 1'b0, 30'h1C824A2B, 1'b1, 12'd3);
    runOp("R6", M_SL, 1'b0, 30'h01083105, 1'b1, 30'h1C824A2B, 1'b1, 12'd0);
  endtask

  task automatic tBusyIgnore();
    logic [29:0] ea, ex;
    logic eerr;
    int elat, lat;
    model(M_SL, 30'h01083105, 30'h1C824A2B, 1'b0, 12'd4, ea, ex, eerr, elat);
    @(negedge clk);
    modeSel = M_SL; aSignIn = 1'b0; aMagIn = 30'h01083105; xSignIn = 1'b0;
    xMagIn = 30'h1C824A2B; cntSign = 1'b0; cntMag = 12'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    @(negedge clk); lat++;
    modeSel = M_RR; aSignIn = 1'b1; aMagIn = 30'h3FFFFFFF; xMagIn = 30'h0; cntMag = 12'd1;
    start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R8", "latency with dropped start", 64'(lat), 64'(elat));
    check("R8", "A after dropped start", 64'(aMagOut), 64'(ea));
    check("R8", "X after dropped start", 64'(xMagOut), 64'(ex));
    check("R8", "sign after dropped start", 64'(aSignOut), 64'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8", "no extra done", 64'(done), 64'd0);
    end
  endtask

  task automatic tHold();
    logic [29:0] ea, ex;
    logic eerr;
    int elat;
    model(M_PR, 30'h2468ACE0, 30'h13579BDF, 1'b0, 12'd2, ea, ex, eerr, elat);
    runOp("R3", M_PR, 1'b0, 30'h2468ACE0, 1'b0, 30'h13579BDF, 1'b0, 12'd2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      aMagIn = 30'h3FFFFFFF - 30'(i); xMagIn = 30'(i); modeSel = M_RL; aSignIn = 1'b1;
    end
    @(negedge clk);
    check("R9", "A held while idle", 64'(aMagOut), 64'(ea));
    check("R9", "X held while idle", 64'(xMagOut), 64'(ex));
    check("R9", "sign held while idle", 64'(aSignOut), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL R7 watchdog: actual no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSingle();
    tPair();
    tRotate();
    tSigns();
    tNegative();
    tBusyIgnore();
    tHold();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule